// File: doc/BRIEF.md
# MDIO Management Host Controller

This block lets a processor read and write the management registers of Ethernet PHYs over the two-wire MDC/MDIO management bus. Software sets up a control word that turns the block on, picks the MDC clock divider and optionally suppresses the preamble. It then writes one packed access word that holds a go/busy flag, the direction, the PHY address, the register address and, for writes, the data. The block serialises one clause-22 management frame, handles the turnaround and captures read data. When the frame ends it clears the busy flag by itself.

Each read also updates a presence bitmap that has one bit per PHY address. A read sets the bit when the addressed PHY pulls the line low in the second turnaround slot, and clears it when no PHY does. Address 31 is never recorded in this bitmap. The serial pins are split into output, output-enable and input, so the bidirectional pad sits outside the block.

Top module: `mdio_host`

## Requirements
- R1: After reset the control readback is 0x8000_0000 (idle flag set, disabled, divider 0). The access readback and the presence bitmap read 0. MDC is low and the output enable is low.
- R2: The control word is written at reg_addr 0 and the access word at reg_addr 1. Control layout: bit 31 is the read-only idle flag, bit 30 is enable, bit 20 suppresses the preamble, bits 7:0 are the divider, and all other bits read 0. Access layout: bit 31 go/busy, bit 30 write (1) or read (0), bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data. An access write with bit 31 set, while enabled and idle, starts a frame. Bit 31 reads 1 until the frame ends and then reads 0, and the idle flag always reads as the inverse of busy.
- R3: One MDC period lasts d+1 clock cycles, where d is the divider with 0 treated as 1. A frame has 64 MDC rising edges, or 32 when the preamble is suppressed. Busy stays set for 64·(d+1)+1 cycles, or 32·(d+1)+1 cycles with the preamble suppressed.
- R4: The bits seen at MDC rising edges are: 32 ones (unless suppressed), start 01, opcode 10 for read or 01 for write, the PHY address, the register address, turnaround 10 for a write, then the 16 data bits. Every field is sent MSB first.
- R5: A read drives the first 14 frame bits and releases the bus (output enable low) from the first turnaround bit to the end. The 16 bits sampled at the data rising edges appear in access bits 15:0 once busy clears.
- R6: At the end of a read from addresses 0 to 30, the presence bit for that address is set if MDIO was low at the second turnaround edge and cleared otherwise. Presence bit 31 always reads 0.
- R7: A write to the access word while busy is ignored. Bits 30:16 keep the values of the running frame and the frame completes normally.
- R8: While enable is 0, a go write starts nothing and changes no access field. Clearing enable during a frame aborts it within two cycles, and the idle flag then reads 1.
- R9: While not busy, MDC is low and the output enable is low. While busy, the MDIO output changes only on the clock edge where MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 = control word, 1 = access word |
| reg_wdata | input | 32 | Register write data |
| ctrl_rd | output | 32 | Control word readback with idle flag |
| access_rd | output | 32 | Access word readback with busy flag and read data |
| alive_rd | output | 32 | PHY presence bitmap |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data input from the pad |

## Verification
The embedded properties check on every cycle that the bus is released and MDC is low when the block is idle. They also check that MDIO moves only with a falling MDC, that busy rises only after a go write, that access fields stay put while a frame runs, and that disabling the block stops it. Only the bench scenarios can show the exact bit stream, the frame length for each divider, read-data capture and the presence bitmap. These depend on a PHY model that answers or stays silent at the right rising edge, and the bench sweeps dividers, both opcodes and both preamble settings to cover them.

// File: rtl/mdio_host.sv
module mdio_host (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] ctrl_rd,
  output logic [31:0] access_rd,
  output logic [31:0] alive_rd,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic        en, presup, busy, wr_op, ack;
  logic [7:0]  div, cnt;
  logic [4:0]  phy, rga;
  logic [15:0] dat, rx;
  logic [6:0]  seq;
  logic [30:0] alive;

  wire [7:0]  d     = (div == 8'd0) ? 8'd1 : div;
  wire [8:0]  dp1   = {1'b0, d} + 9'd1;
  wire [7:0]  h     = dp1[8:1];
  wire [31:0] fw    = {2'b01, wr_op ? 2'b01 : 2'b10, phy, rga, 2'b10, dat};
  wire        fbit  = fw[5'd31 - seq[4:0]];
  wire        start = reg_wr && reg_addr == 2'd1 && reg_wdata[31] && en && !busy;
  wire        unused_bits = ^{reg_wdata[29:26], reg_wdata[19:8]};

  assign ctrl_rd   = {~busy, en, 9'd0, presup, 12'd0, div};
  assign access_rd = {busy, wr_op, 4'd0, rga, phy, dat};
  assign alive_rd  = {1'b0, alive};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; presup <= 1'b0; div <= 8'd0;
      busy <= 1'b0; wr_op <= 1'b0; phy <= 5'd0; rga <= 5'd0; dat <= 16'd0;
      rx <= 16'd0; ack <= 1'b0; cnt <= 8'd0; seq <= 7'd0;
      mdc <= 1'b0; mdio_out <= 1'b1; mdio_oe <= 1'b0; alive <= 31'd0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) begin
        en     <= reg_wdata[30];
        presup <= reg_wdata[20];
        div    <= reg_wdata[7:0];
      end
      if (!en) begin
        busy <= 1'b0; mdc <= 1'b0; mdio_oe <= 1'b0;
      end else if (start) begin
        busy  <= 1'b1;
        wr_op <= reg_wdata[30];
        rga   <= reg_wdata[25:21];
        phy   <= reg_wdata[20:16];
        dat   <= reg_wdata[15:0];
        cnt   <= 8'd0;
        seq   <= presup ? 7'd32 : 7'd0;
      end else if (busy) begin
        cnt <= (cnt >= d) ? 8'd0 : cnt + 8'd1;
        if (cnt == 8'd0) begin
          mdc <= 1'b0;
          if (seq == 7'd64) begin
            busy <= 1'b0; mdio_oe <= 1'b0;
            if (!wr_op) begin
              dat <= rx;
              if (phy != 5'd31) alive[phy] <= ack;
            end
          end else if (!seq[5]) begin
            mdio_out <= 1'b1; mdio_oe <= 1'b1;
          end else begin
            mdio_out <= fbit;
            mdio_oe  <= wr_op || seq[4:0] < 5'd14;
          end
        end
        if (cnt == h) begin
          mdc <= 1'b1;
          seq <= seq + 7'd1;
          if (seq == 7'd47) ack <= !mdio_in;
          if (seq >= 7'd48) rx <= {rx[14:0], mdio_in};
        end
      end
    end
  end

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));
  assert_data_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_out)) |-> !mdc);
  assert_go_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == 2'd1 && reg_wdata[31]));
  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd1) |=> $stable(access_rd[30:16]));
  assert_disable_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
endmodule

// File: tb/mdio_host_tb.sv
module mdio_host_tb;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] ctrl_rd, access_rd, alive_rd;
  logic mdc, mdio_out, mdio_oe, mdio_in;
  int nchk = 0, nfail = 0, redges = 0, pre = 32;
  logic resp_en = 1'b0, done = 1'b0;
  logic [15:0] resp_data = 16'd0;
  logic [63:0] cap_o, cap_oe;
  logic [31:0] exp_alive = 32'd0;

  always #5 clk = ~clk;

  mdio_host u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .access_rd(access_rd), .alive_rd(alive_rd),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in));

  assign mdio_in = !resp_en ? 1'b1 :
                   (redges == pre + 15) ? 1'b0 :
                   (redges >= pre + 16 && redges < pre + 32) ? resp_data[15 - (redges - pre - 16)] : 1'b1;

  always @(posedge mdc) begin
    if (redges < 64) begin
      cap_o[redges]  <= mdio_out;
      cap_oe[redges] <= mdio_oe;
    end
    redges <= redges + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic frame(input logic w, input logic [4:0] ph, input logic [4:0] rg,
                       input logic [15:0] dv, input logic [7:0] dvd, input logic ps,
                       input logic resp, input logic [15:0] rdv);
    int busy_n, d, nb;
    logic [31:0] fw;
    logic [63:0] ev, em;
    d  = (dvd == 0) ? 1 : int'(dvd);
    nb = ps ? 32 : 64;
    wreg(2'd0, {1'b0, 1'b1, 9'd0, ps, 12'd0, dvd});
    pre = ps ? 0 : 32; resp_en = resp; resp_data = rdv; redges = 0;
    cap_o = '0; cap_oe = '0;
    wreg(2'd1, {1'b1, w, 4'd0, rg, ph, dv});
    busy_n = 0;
    while (access_rd[31]) begin
      busy_n++;
      check("R2 idle flag inverse of busy", {31'd0, ctrl_rd[31]}, 32'd0);
      @(negedge clk);
    end
    check("R3 busy cycles", busy_n, nb * (d + 1) + 1);
    check("R3 mdc rising edges", redges, nb);
    check("R2 idle after frame", {31'd0, ctrl_rd[31]}, 32'd1);
    fw = {2'b01, w ? 2'b01 : 2'b10, ph, rg, 2'b10, dv};
    ev = '0; em = '0;
    for (int i = 0; i < nb; i++) begin
      if (i < pre) begin ev[i] = 1'b1; em[i] = 1'b1; end
      else begin
        ev[i] = fw[31 - (i - pre)];
        em[i] = w || (i - pre) < 14;
      end
    end
    check(w ? "R4 oe pattern low" : "R5 oe pattern low", cap_oe[31:0], em[31:0]);
    check(w ? "R4 oe pattern high" : "R5 oe pattern high", cap_oe[63:32], em[63:32]);
    check("R4 stream low", cap_o[31:0] & em[31:0], ev[31:0] & em[31:0]);
    check("R4 stream high", cap_o[63:32] & em[63:32], ev[63:32] & em[63:32]);
    if (w) check("R2 access after write", access_rd, {1'b0, 1'b1, 4'd0, rg, ph, dv});
    else begin
      check("R5 read data", {16'd0, access_rd[15:0]}, {16'd0, resp ? rdv : 16'hffff});
      if (ph != 5'd31) exp_alive[ph] = resp;
      check("R6 presence bitmap", alive_rd, exp_alive);
    end
    check("R9 idle pins", {30'd0, mdc, mdio_oe}, 32'd0);
    resp_en = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 control reset", ctrl_rd, 32'h8000_0000);
    check("R1 access reset", access_rd, 32'd0);
    check("R1 alive reset", alive_rd, 32'd0);
    check("R1 pins reset", {30'd0, mdc, mdio_oe}, 32'd0);

    for (int k = 0; k < 5; k++) begin
      for (int ps = 0; ps < 2; ps++) begin
        for (int w = 0; w < 2; w++) begin
          logic [7:0] dvd;
          dvd = (k == 4) ? 8'd6 : 8'(k);
          frame(w[0], 5'(k * 7 + ps * 3 + w), 5'(31 - k * 5 - w),
                16'(16'hA5C3 ^ (k * 16'h1357) ^ (ps * 16'h0F0F)),
                dvd, ps[0], ((k + ps) % 2) == 0, 16'(16'h3C96 + k * 16'h0421 + w));
        end
      end
    end
    frame(1'b0, 5'd9, 5'd1, 16'd0, 8'd2, 1'b0, 1'b1, 16'h1234);
    frame(1'b0, 5'd9, 5'd1, 16'd0, 8'd2, 1'b0, 1'b0, 16'h0);
    frame(1'b0, 5'd31, 5'd2, 16'd0, 8'd1, 1'b1, 1'b1, 16'hBEEF);
    check("R6 address 31 never recorded", {31'd0, alive_rd[31]}, 32'd0);

    // R7: write while busy
    wreg(2'd0, {2'b01, 9'd0, 1'b0, 12'd0, 8'd3});
    redges = 0;
    wreg(2'd1, {1'b1, 1'b1, 4'd0, 5'd4, 5'd12, 16'h6E6E});
    hold = access_rd;
    repeat (10) @(negedge clk);
    wreg(2'd1, {1'b1, 1'b0, 4'd0, 5'd30, 5'd1, 16'h0001});
    check("R7 busy after ignored write", {31'd0, access_rd[31]}, 32'd1);
    check("R7 fields held", {17'd0, access_rd[30:16]}, {17'd0, hold[30:16]});
    while (access_rd[31]) @(negedge clk);
    check("R7 frame completes unchanged", access_rd, {1'b0, 1'b1, 4'd0, 5'd4, 5'd12, 16'h6E6E});
    check("R7 full frame length", redges, 64);

    // R8: disabled go is ignored
    hold = access_rd;
    wreg(2'd0, 32'h0000_0002);
    wreg(2'd1, {1'b1, 1'b0, 4'd0, 5'd7, 5'd7, 16'h7777});
    @(negedge clk);
    check("R8 go ignored when disabled", access_rd, hold);
    check("R8 idle when disabled", {31'd0, ctrl_rd[31]}, 32'd1);
    check("R8 pins quiet when disabled", {30'd0, mdc, mdio_oe}, 32'd0);
    // R8: abort mid-frame
    wreg(2'd0, {2'b01, 9'd0, 1'b0, 12'd0, 8'd2});
    wreg(2'd1, {1'b1, 1'b0, 4'd0, 5'd3, 5'd3, 16'h0});
    repeat (20) @(negedge clk);
    check("R8 busy before abort", {31'd0, access_rd[31]}, 32'd1);
    wreg(2'd0, 32'h0000_0002);
    @(negedge clk);
    check("R8 aborted", {31'd0, access_rd[31]}, 32'd0);
    check("R8 idle after abort", {31'd0, ctrl_rd[31]}, 32'd1);
    check("R9 pins after abort", {30'd0, mdc, mdio_oe}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule